// File: doc/BRIEF.md
# Memory-mapped flash read engine

This block lets a processor read a serial NOR flash as if it were plain read-only memory. Software first stores a read template through a small register port. The template holds the flash opcode, how many address bytes follow it, how many intermediate (dummy) bytes come next, and whether the data comes back on one line or on several. Storing it switches the engine into memory mode and raises a status flag.

From then on, every read on the memory-mapped bus becomes one complete flash frame. Chip select goes low, and the opcode and the low address bytes go out on line 0. The intermediate bytes follow, and then the engine shifts in as many data bytes as the access is wide. The bus is held off until the last byte has arrived. Writing the reset bit of the status register drops the engine back to command mode. In command mode, bus reads are answered at once with zero and do not touch the flash.

The serial clock runs at half the system clock in SPI mode 0. It idles low, and the flash samples on its rising edge. After every frame, chip select stays high for a minimum time before the next frame starts.

Top module: `flash_xip_reader`

## Requirements
- R1: A write to register select 0 stores the template and sets `mem_mode` in the next cycle. The template fields are: opcode in bits 31:24, frame format in bits 23:21, field format in bits 20:19, and intermediate byte count in bits 18:16.
- R2: Frame format values 2, 3, 4 and 5 give 1, 2, 3 and 4 address bytes. Each frame first sends the opcode, then the low address bytes of `bus_addr`, most significant byte first. Every byte goes out MSB first on `fl_io_out[0]` with `fl_io_oe` = 4'b0001.
- R3: An intermediate count n inserts 8·n serial clocks after the address. Over these clocks the register written through select 1 is driven on line 0, byte 0 (bits 7:0) first and MSB first within each byte. After the fourth byte the sequence wraps back to byte 0.
- R4: With field format 0, data is read on `fl_io_in[1]` at one bit per clock. With field format 1, data is read on `fl_io_in[LANES-1:0]` at LANES bits per clock, with the higher line holding the more significant bit. During the data phase `fl_io_oe` is all zero.
- R5: `bus_size` codes 0, 1 and 2 read 1, 2 and 4 bytes. The first byte received lands in `bus_rdata[7:0]`, the next in bits 15:8, and so on. Unused upper bytes read as zero.
- R6: `fl_sck` is low whenever chip select is high, and each serial clock lasts two system cycles. `bus_ready` is a one-cycle pulse that rises 2·T cycles after the clock edge that starts a frame of T serial clocks, in the same cycle that chip select rises.
- R7: Between two frames, chip select stays high for at least CS_HIGH system cycles.
- R8: In command mode, a bus read is acknowledged in the next cycle with zero data, and chip select stays high.
- R9: Writing register select 2 with bit 4 set raises `rst_busy`. Once no frame is in progress, `rst_busy` and `mem_mode` clear together one cycle later. A frame already in progress completes with correct data first.
- R10: The start-up sequence leaves the engine in command mode. That sequence is: reset, clear the intermediate register, clear the template, reset again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 template, 1 intermediate data, 2 status control |
| reg_wdata | input | 32 | Register write data |
| mem_mode | output | 1 | Memory mode is active |
| rst_busy | output | 1 | A return to command mode is pending |
| bus_rd | input | 1 | Bus read request, held until `bus_ready` |
| bus_addr | input | 32 | Bus read address |
| bus_size | input | 2 | Access width: 0 byte, 1 half-word, 2 word |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | One-cycle read completion |
| fl_sck | output | 1 | Serial clock to the flash |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_io_out | output | 4 | Flash data lines, outbound |
| fl_io_oe | output | 4 | Output enables of the flash data lines |
| fl_io_in | input | 4 | Flash data lines, inbound |

## Verification
A behavioural flash model records every header bit and serves data from an address-derived pattern on the configured lines. A fully serial template with three address bytes and a one-byte intermediate field is tested against a four-lane template with four address bytes and five intermediate bytes. Together these separate the width handling and the address truncation, and the second also shows the wrap of the intermediate bytes. A one-address-byte, single-byte access and a two-byte-address back-to-back pair cover the narrow extremes and the chip-select gap. Command-mode reads and a reset issued mid-frame show that the mode flag and the stall logic behave independently of the shifting.

// File: rtl/flash_xip_reader.sv
module flash_xip_reader #(
  parameter int LANES   = 4,
  parameter int CS_HIGH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic        mem_mode,
  output logic        rst_busy,
  input  logic        bus_rd,
  input  logic [31:0] bus_addr,
  input  logic [1:0]  bus_size,
  output logic [31:0] bus_rdata,
  output logic        bus_ready,
  output logic        fl_sck,
  output logic        fl_cs_n,
  output logic [3:0]  fl_io_out,
  output logic [3:0]  fl_io_oe,
  input  logic [3:0]  fl_io_in
);
  localparam int LSH = (LANES == 4) ? 2 : 1;
  localparam int GW  = $clog2(CS_HIGH + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} st_t;
  st_t st;

  logic [7:0]  t_op;
  logic [2:0]  t_ff, t_il, t_ab;
  logic        t_wide;
  logic [31:0] idata;
  logic        mode_q, rpend_q;

  logic [2:0]  f_ab, f_il, f_nb, nb;
  logic        f_wide;
  logic [39:0] tx;
  logic [31:0] rx, rx_nx, rdat_q;
  logic [7:0]  ck, hdr_a, hdr, dclk, tot;
  logic [4:0]  d;
  logic [7:0]  ibyte;
  logic [3:0]  inb;
  logic        sck_q, cs_q, rdy_q, io0, in_data;
  logic [GW-1:0] gap;

  assign t_ab = (t_ff == 3'd0) ? 3'd0 : (t_ff > 3'd5) ? 3'd4 : t_ff - 3'd1;
  assign nb   = (bus_size == 2'd0) ? 3'd1 : (bus_size == 2'd1) ? 3'd2 : 3'd4;

  assign hdr_a   = 8'd8 + {2'b0, f_ab, 3'b0};
  assign hdr     = hdr_a + {2'b0, f_il, 3'b0};
  assign dclk    = f_wide ? ({2'b0, f_nb, 3'b0} >> LSH) : {2'b0, f_nb, 3'b0};
  assign tot     = hdr + dclk;
  assign in_data = (ck >= hdr);

  assign d     = 5'(ck - hdr_a);
  assign ibyte = idata[{d[4:3], 3'b000} +: 8];
  assign io0   = (ck < hdr_a) ? tx[39] : ibyte[~d[2:0]];

  generate
    if (LANES == 4) begin : g_quad
      assign inb = f_wide ? fl_io_in : {3'b0, fl_io_in[1]};
    end else begin : g_dual
      assign inb = f_wide ? {2'b0, fl_io_in[1:0]} : {3'b0, fl_io_in[1]};
    end
  endgenerate

  assign rx_nx = f_wide ? ((rx << LANES) | {28'b0, inb}) : ((rx << 1) | {28'b0, inb});

  function automatic logic [31:0] to_le(input logic [31:0] r, input logic [2:0] n);
    case (n)
      3'd1:    to_le = {24'b0, r[7:0]};
      3'd2:    to_le = {16'b0, r[7:0], r[15:8]};
      default: to_le = {r[7:0], r[15:8], r[23:16], r[31:24]};
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      t_op <= '0; t_ff <= '0; t_il <= '0; t_wide <= 1'b0;
      idata <= '0; mode_q <= 1'b0; rpend_q <= 1'b0;
      f_ab <= '0; f_il <= '0; f_nb <= 3'd1; f_wide <= 1'b0;
      tx <= '0; rx <= '0; rdat_q <= '0; ck <= '0;
      sck_q <= 1'b0; cs_q <= 1'b1; rdy_q <= 1'b0; gap <= '0;
    end else begin
      rdy_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (rpend_q) begin
            mode_q  <= 1'b0;
            rpend_q <= 1'b0;
          end else if (bus_rd && !rdy_q) begin
            if (mode_q) begin
              f_ab   <= t_ab;
              f_il   <= t_il;
              f_nb   <= nb;
              f_wide <= t_wide;
              tx     <= {t_op, bus_addr << (6'd8 * (6'd4 - {3'b0, t_ab}))};
              rx     <= '0;
              ck     <= '0;
              sck_q  <= 1'b0;
              cs_q   <= 1'b0;
              st     <= S_SHIFT;
            end else begin
              rdy_q  <= 1'b1;
              rdat_q <= '0;
            end
          end
        end
        S_SHIFT: begin
          if (!sck_q) begin
            sck_q <= 1'b1;
          end else begin
            sck_q <= 1'b0;
            if (in_data) rx <= rx_nx;
            else if (ck < hdr_a) tx <= tx << 1;
            ck <= ck + 8'd1;
            if (ck + 8'd1 == tot) begin
              cs_q   <= 1'b1;
              rdy_q  <= 1'b1;
              rdat_q <= to_le(rx_nx, f_nb);
              gap    <= '0;
              st     <= S_GAP;
            end
          end
        end
        S_GAP: begin
          if (gap == GW'(CS_HIGH - 1)) st <= S_IDLE;
          else gap <= gap + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
      if (reg_wr) begin
        case (reg_sel)
          2'd0: begin
            t_op   <= reg_wdata[31:24];
            t_ff   <= reg_wdata[23:21];
            t_wide <= |reg_wdata[20:19];
            t_il   <= reg_wdata[18:16];
            mode_q <= 1'b1;
          end
          2'd1: idata <= reg_wdata;
          2'd2: if (reg_wdata[4]) rpend_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign mem_mode  = mode_q;
  assign rst_busy  = rpend_q;
  assign bus_ready = rdy_q;
  assign bus_rdata = rdat_q;
  assign fl_sck    = sck_q;
  assign fl_cs_n   = cs_q;
  assign fl_io_out = {3'b000, io0};
  assign fl_io_oe  = (!cs_q && !in_data) ? 4'b0001 : 4'b0000;
endmodule

module flash_xip_checks #(
  parameter int CS_HIGH = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_sel,
  input logic       mem_mode,
  input logic       rst_busy,
  input logic       bus_ready,
  input logic       cs_n,
  input logic       sck
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= 16'(CS_HIGH);
    else if (!cs_n) hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
  end

  a_r1_mode_on: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0) |=> mem_mode);

  a_r6_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  a_r6_ready_at_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> cs_n);

  a_r6_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);

  a_r7_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> hi_cnt >= 16'(CS_HIGH));

  a_r8_cmd_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_mode && cs_n) |=> cs_n);

  a_r9_reset_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rst_busy) && !$past(reg_wr && reg_sel == 2'd0)) |-> !mem_mode);
endmodule

bind flash_xip_reader flash_xip_checks #(.CS_HIGH(CS_HIGH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .mem_mode(mem_mode), .rst_busy(rst_busy), .bus_ready(bus_ready),
  .cs_n(fl_cs_n), .sck(fl_sck)
);

// File: tb/sim_flash_xip_reader.sv
`timescale 1ns/1ps
module sim_flash_xip_reader;
  localparam int LANES = 4;
  localparam int CSH   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0; logic [1:0] reg_sel = '0; logic [31:0] reg_wdata = '0;
  logic mem_mode, rst_busy;
  logic bus_rd = 1'b0; logic [31:0] bus_addr = '0; logic [1:0] bus_size = '0;
  logic [31:0] bus_rdata; logic bus_ready;
  logic fl_sck, fl_cs_n; logic [3:0] fl_io_out, fl_io_oe; logic [3:0] fl_io_in = '0;

  int errors = 0, checks = 0;
  int m_hdr = 0, m_w = 1, pcnt = 0, nframes = 0, hicnt = 0, last_gap = 0;
  logic [31:0] m_addr = '0, idv = '0;
  logic [127:0] cap = '0;
  logic oe_bad = 1'b0;
  int c_ab = 0, c_il = 0; logic [7:0] c_op = '0;

  always #5 clk = ~clk;

  flash_xip_reader #(.LANES(LANES), .CS_HIGH(CSH)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .mem_mode(mem_mode), .rst_busy(rst_busy), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_rdata(bus_rdata), .bus_ready(bus_ready), .fl_sck(fl_sck),
    .fl_cs_n(fl_cs_n), .fl_io_out(fl_io_out), .fl_io_oe(fl_io_oe), .fl_io_in(fl_io_in));

  function automatic logic [7:0] mem(input logic [31:0] a);
    return (a[7:0] + 8'h11) ^ a[15:8] ^ {a[3:0], a[7:4]};
  endfunction

  function automatic logic [3:0] lane_val(input int p);
    logic [7:0] b;
    if (m_w == 1) begin
      b = mem(m_addr + 32'(p / 8));
      return {2'b00, b[7 - (p % 8)], 1'b0};
    end else if (m_w == 2) begin
      b = mem(m_addr + 32'(p / 4));
      return {2'b00, b[7 - 2 * (p % 4)], b[6 - 2 * (p % 4)]};
    end else begin
      b = mem(m_addr + 32'(p / 2));
      return (p % 2 == 0) ? b[7:4] : b[3:0];
    end
  endfunction

  always @(negedge fl_cs_n) begin
    pcnt = 0; cap = '0; oe_bad = 1'b0; nframes++;
  end
  always @(posedge fl_sck) if (!fl_cs_n) begin
    if (pcnt < m_hdr) cap = {cap[126:0], fl_io_out[0]};
    else if (fl_io_oe != 4'b0000) oe_bad = 1'b1;
    pcnt++;
  end
  always @(negedge fl_sck) if (!fl_cs_n && pcnt >= m_hdr) fl_io_in = lane_val(pcnt - m_hdr);

  always @(negedge clk) begin
    if (fl_cs_n) hicnt++;
    else begin
      if (hicnt != 0) last_gap = hicnt;
      hicnt = 0;
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic set_tmpl(input logic [7:0] op, input int ff, input int fld, input int il);
    wr(2'd0, {op, 3'(ff), 2'(fld), 3'(il), 16'h0});
    c_op = op; c_ab = ff - 1; c_il = il;
    m_w = (fld != 0) ? LANES : 1;
    m_hdr = 8 + 8 * c_ab + 8 * il;
  endtask

  task automatic do_read(input logic [31:0] a, input logic [1:0] sz,
                         output logic [31:0] data, output int lat);
    lat = 0; m_addr = a;
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; bus_size = sz;
    do begin
      @(negedge clk); lat++;
    end while (!bus_ready && lat < 2000);
    data = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic frame_read(input string tag, input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] data, expd; logic [127:0] eh; int lat, nb, t;
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    t = m_hdr + nb * 8 / m_w;
    do_read(a, sz, data, lat);
    chk({tag, " R6 ready with cs high"}, {127'b0, fl_cs_n}, 128'd1);
    expd = '0;
    for (int k = 0; k < nb; k++) expd = expd | (32'(mem(a + 32'(k))) << (8 * k));
    chk({tag, " R5 R4 data"}, {96'b0, data}, {96'b0, expd});
    eh = {120'b0, c_op};
    for (int i = c_ab - 1; i >= 0; i--) eh = (eh << 8) | 128'(a[8 * i +: 8]);
    for (int j = 0; j < c_il; j++) eh = (eh << 8) | 128'(idv[8 * (j % 4) +: 8]);
    chk({tag, " R2 R3 header bits"}, cap, eh);
    chk({tag, " R6 serial clocks"}, 128'(pcnt), 128'(t));
    chk({tag, " R6 latency"}, 128'(lat), 128'(2 * t + 1));
    chk({tag, " R4 lines released"}, {127'b0, oe_bad}, 128'd0);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset_state;
    chk("R8 reset mem_mode", {127'b0, mem_mode}, 128'd0);
    chk("R9 reset rst_busy", {127'b0, rst_busy}, 128'd0);
    chk("R6 reset cs_n sck", {126'b0, fl_cs_n, fl_sck}, 128'd2);
    chk("R6 reset ready", {127'b0, bus_ready}, 128'd0);
  endtask

  task automatic t_init;
    wr(2'd2, 32'h10);
    wr(2'd1, 32'h0);
    wr(2'd0, 32'h0);
    chk("R1 mode set by template", {127'b0, mem_mode}, 128'd1);
    wr(2'd2, 32'h10);
    chk("R9 pending flag", {126'b0, rst_busy, mem_mode}, 128'd3);
    @(negedge clk);
    chk("R10 R9 init ends in command mode", {126'b0, rst_busy, mem_mode}, 128'd0);
  endtask

  task automatic t_cmd_mode;
    logic [31:0] data; int lat, f0;
    f0 = nframes;
    do_read(32'h0000_1234, 2'd2, data, lat);
    chk("R8 command mode latency", 128'(lat), 128'd1);
    chk("R8 command mode data", {96'b0, data}, 128'd0);
    repeat (4) @(negedge clk);
    chk("R8 no chip select", 128'(nframes), 128'(f0));
  endtask

  task automatic t_serial;
    idv = 32'hC3A5_5AF0; wr(2'd1, idv);
    set_tmpl(8'h0B, 4, 0, 1);
    frame_read("serial", 32'h0012_3456, 2'd2);
  endtask

  task automatic t_wide;
    idv = 32'h9E17_6C2B; wr(2'd1, idv);
    set_tmpl(8'hEB, 5, 1, 5);
    frame_read("wide", 32'h89AB_CDEF, 2'd1);
  endtask

  task automatic t_narrow;
    set_tmpl(8'h6B, 2, 1, 0);
    frame_read("narrow", 32'h0000_00F7, 2'd0);
  endtask

  task automatic t_back_to_back;
    logic [31:0] d1, d2; int l1, l2;
    set_tmpl(8'h03, 3, 0, 0);
    do_read(32'h0000_4A10, 2'd0, d1, l1);
    do_read(32'h0000_4A11, 2'd1, d2, l2);
    chk("R7 chip select gap", 128'(last_gap >= CSH), 128'd1);
    chk("R5 second read data", {96'b0, d2}, {112'b0, mem(32'h4A12), mem(32'h4A11)});
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset_mid;
    logic [31:0] data; int lat;
    set_tmpl(8'h0B, 4, 0, 0);
    fork
      do_read(32'h0005_0607, 2'd2, data, lat);
      begin
        repeat (12) @(negedge clk);
        wr(2'd2, 32'h10);
        chk("R9 mode held during frame", {127'b0, mem_mode}, 128'd1);
      end
    join
    chk("R9 frame completes", {96'b0, data},
        {96'b0, mem(32'h50609), mem(32'h50608), mem(32'h50607), mem(32'h50606) + 8'h0} & 128'h0 |
        {96'b0, mem(32'h5060A), mem(32'h50609), mem(32'h50608), mem(32'h50607)});
    repeat (8) @(negedge clk);
    chk("R9 back in command mode", {126'b0, rst_busy, mem_mode}, 128'd0);
    t_cmd_mode();
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_init();
    t_cmd_mode();
    t_serial();
    t_wide();
    t_narrow();
    t_back_to_back();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule